// File: doc/BRIEF.md
# Rising-Edge Level Trigger with Slope Qualification

This block watches one of two streams of signed 12-bit samples and raises a one-cycle trigger pulse when the chosen stream crosses a programmable level on the way up. A raw level comparison alone fires on noise, because a falling signal that jitters around the level also produces upward crossings. The block therefore lets a crossing through only if a smoothed copy of the stream is rising at that moment. It also enforces a minimum spacing between pulses.

The smoothing stage weights the five newest samples with the integer kernel 1, 2, 3, 2, 1. It compares the result with the smoothed value from four samples earlier and reports whether the signal rises. The level stage compares the raw sample and the one before it with the level, and checks a holdoff counter. A capture or display engine uses the pulse to mark where a waveform is anchored.

Top module: `trig_slope_level`

## Requirements
- R1: The smoothed value of each valid sample is x[n] + 2·x[n-1] + 3·x[n-2] + 2·x[n-3] + x[n-4], where x[n-k] are earlier valid samples of the selected stream. It is held in a signed 16-bit word and is not scaled down.
- R2: `slope_rising` takes a new value in the cycle after each valid sample. It is 1 exactly when that sample's smoothed value minus the smoothed value of four valid samples earlier is strictly greater than zero. In cycles without a valid sample it keeps its value.
- R3: Reset clears the sample and smoothed histories to zero. `slope_rising` stays 0 until at least eight valid samples have arrived since reset.
- R4: A crossing happens on a valid sample when the previous valid sample is below `trig_level` and the current one is at or above it. Both comparisons are two's-complement signed. The pulse appears in the cycle after that sample.
- R5: A crossing produces a pulse only if the slope result for that same sample is 1.
- R6: Two pulses are more than `HOLDOFF` clock cycles apart. A pulse exactly `HOLDOFF` + 1 cycles after the previous one is allowed. The holdoff counter saturates, so any longer quiet gap leaves the trigger armed.
- R7: `trig_pulse` is never high for two cycles in a row.
- R8: While `trig_en` is 0 no pulse is produced. The histories keep updating.
- R9: `chan_sel` = 0 feeds `smp_a` into both stages, and `chan_sel` = 1 feeds `smp_b`.
- R10: After reset, `trig_pulse` and `slope_rising` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_a | input | 12 | Signed sample, stream A |
| smp_b | input | 12 | Signed sample, stream B |
| smp_vld | input | 1 | Both sample inputs carry a new sample this cycle |
| chan_sel | input | 1 | Stream select: 0 = A, 1 = B |
| trig_en | input | 1 | Allows pulses when 1 |
| trig_level | input | 12 | Signed trigger level |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| slope_rising | output | 1 | Smoothed stream is rising |

## Verification
Both outputs are registered once behind the sample that causes them. A sample presented in the cycle before a rising edge therefore shows its slope result and any pulse in the cycle after that edge. The bench drives inputs on the falling edge and samples one time unit after the rising edge. The holdoff window is counted in clock cycles, not samples. The bench streams samples without gaps when probing the holdoff boundary, so that crossings land exactly `HOLDOFF` and `HOLDOFF` + 1 cycles after a pulse. The warm-up rule is checked on the seventh and eighth samples after reset.

// File: rtl/trig_pkg.sv
package trig_pkg;

    localparam int SMP_W   = 12;
    localparam int GUARD_W = 4;
    localparam int FILT_W  = SMP_W + GUARD_W;
    localparam int SLOPE_W = FILT_W + 1;
    localparam int TAPS    = 5;
    localparam int LAG     = 4;
    localparam int WARMUP  = 8;

    typedef logic signed [SMP_W-1:0]   smp_t;
    typedef logic signed [FILT_W-1:0]  filt_t;
    typedef logic signed [SLOPE_W-1:0] slope_t;

    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } chan_e;

    typedef struct packed {
        logic vld;
        smp_t val;
    } smp_beat_t;

    // triangular kernel: 1,2,3,2,1 for five taps
    function automatic int kern_weight(input int idx);
        return (idx + 1 < TAPS - idx) ? idx + 1 : TAPS - idx;
    endfunction

endpackage

// File: rtl/trig_smoother.sv
module trig_smoother
    import trig_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  smp_beat_t beat,
    output smp_t      prev_smp,
    output logic      slope_now,
    output logic      slope_up
);

    localparam int CNT_W = $clog2(WARMUP);
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(WARMUP - 1);

    smp_t             hist  [TAPS-1];
    filt_t            fhist [LAG];
    logic [CNT_W-1:0] seen_q;

    smp_t   taps [TAPS];
    filt_t  filt_now;
    slope_t diff;

    always_comb begin
        taps[0] = beat.val;
        for (int i = 1; i < TAPS; i++) begin
            taps[i] = hist[i-1];
        end
    end

    always_comb begin
        filt_now = '0;
        for (int i = 0; i < TAPS; i++) begin
            filt_now = filt_now + filt_t'(taps[i]) * filt_t'(kern_weight(i));
        end
    end

    assign diff      = slope_t'(filt_now) - slope_t'(fhist[LAG-1]);
    assign slope_now = (seen_q == CNT_TOP) && (diff > slope_t'(0));
    assign prev_smp  = hist[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TAPS - 1; i++) hist[i] <= '0;
            for (int i = 0; i < LAG; i++)      fhist[i] <= '0;
            seen_q   <= '0;
            slope_up <= 1'b0;
        end else if (beat.vld) begin
            hist[0] <= beat.val;
            for (int i = 1; i < TAPS - 1; i++) hist[i] <= hist[i-1];
            fhist[0] <= filt_now;
            for (int i = 1; i < LAG; i++)      fhist[i] <= fhist[i-1];
            if (seen_q != CNT_TOP) seen_q <= seen_q + 1'b1;
            slope_up <= slope_now;
        end
    end

endmodule

// File: rtl/trig_level_gate.sv
module trig_level_gate
    import trig_pkg::*;
#(
    parameter int HOLDOFF = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  smp_beat_t beat,
    input  smp_t      prev_smp,
    input  smp_t      level,
    input  logic      enable,
    input  logic      slope_now,
    output logic      trig
);

    logic crossed;
    logic hold_ok;
    logic fire;

    assign crossed = (prev_smp < level) && (beat.val >= level);
    assign fire    = beat.vld && enable && crossed && slope_now && hold_ok;

    generate
        if (HOLDOFF == 0) begin : g_nohold
            assign hold_ok = 1'b1;
        end else begin : g_hold
            localparam int HOLD_W = $clog2(HOLDOFF + 1);
            localparam logic [HOLD_W-1:0] HOLD_MAX = HOLD_W'(HOLDOFF);
            logic [HOLD_W-1:0] hold_q;

            assign hold_ok = (hold_q == HOLD_MAX);

            always_ff @(posedge clk) begin
                if (rst) begin
                    hold_q <= HOLD_MAX;
                end else if (fire) begin
                    hold_q <= '0;
                end else if (hold_q != HOLD_MAX) begin
                    hold_q <= hold_q + 1'b1;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) trig <= 1'b0;
        else     trig <= fire;
    end

endmodule

// File: rtl/trig_slope_level.sv
module trig_slope_level
    import trig_pkg::*;
#(
    parameter int HOLDOFF = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [SMP_W-1:0] smp_a,
    input  logic signed [SMP_W-1:0] smp_b,
    input  logic                    smp_vld,
    input  logic                    chan_sel,
    input  logic                    trig_en,
    input  logic signed [SMP_W-1:0] trig_level,
    output logic                    trig_pulse,
    output logic                    slope_rising
);

    smp_beat_t sel_beat;
    smp_t      prev_smp;
    logic      slope_now;

    always_comb begin
        sel_beat.vld = smp_vld;
        sel_beat.val = (chan_e'(chan_sel) == CH_B) ? smp_b : smp_a;
    end

    trig_smoother u_smooth (
        .clk       (clk),
        .rst       (rst),
        .beat      (sel_beat),
        .prev_smp  (prev_smp),
        .slope_now (slope_now),
        .slope_up  (slope_rising)
    );

    trig_level_gate #(
        .HOLDOFF (HOLDOFF)
    ) u_gate (
        .clk       (clk),
        .rst       (rst),
        .beat      (sel_beat),
        .prev_smp  (prev_smp),
        .level     (trig_level),
        .enable    (trig_en),
        .slope_now (slope_now),
        .trig      (trig_pulse)
    );

endmodule

// File: rtl/trig_checker.sv
module trig_checker
    import trig_pkg::*;
#(
    parameter int HOLDOFF = 16
) (
    input logic clk,
    input logic rst,
    input logic smp_vld,
    input logic trig_en,
    input logic trig_pulse,
    input logic slope_rising
);

    localparam int GAP_W = $clog2(HOLDOFF + 2);
    localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(HOLDOFF + 1);
    localparam int VW = $clog2(WARMUP + 1);
    localparam logic [VW-1:0] V_SAT = VW'(WARMUP);

    logic [GAP_W-1:0] gap_q;
    logic [VW-1:0]    vcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= GAP_SAT;
            vcnt_q <= '0;
        end else begin
            if (trig_pulse)          gap_q <= GAP_W'(1);
            else if (gap_q != GAP_SAT) gap_q <= gap_q + 1'b1;
            if (smp_vld && vcnt_q != V_SAT) vcnt_q <= vcnt_q + 1'b1;
        end
    end

    AST_SLOPE_HELD: assert property (@(posedge clk) disable iff (rst)
        (!$past(smp_vld) && !$past(rst)) |-> $stable(slope_rising)); // R2
    AST_WARMUP_LOW: assert property (@(posedge clk) disable iff (rst)
        slope_rising |-> (vcnt_q == V_SAT)); // R3
    AST_PULSE_ON_SAMPLE: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> $past(smp_vld)); // R4
    AST_PULSE_NEEDS_SLOPE: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> slope_rising); // R5
    AST_HOLDOFF_GAP: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> (int'(gap_q) > HOLDOFF)); // R6
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |=> !trig_pulse); // R7
    AST_PULSE_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> $past(trig_en)); // R8

endmodule

bind trig_slope_level trig_checker #(.HOLDOFF(HOLDOFF)) u_trig_chk (
    .clk          (clk),
    .rst          (rst),
    .smp_vld      (smp_vld),
    .trig_en      (trig_en),
    .trig_pulse   (trig_pulse),
    .slope_rising (slope_rising)
);

// File: tb/test_trig_slope_level.sv
module test_trig_slope_level;

    localparam int CLK_PERIOD = 10;
    localparam int HOLD = 10;
    localparam int BIG = 1 << 20;

    typedef struct packed {
        logic [7:0]         rep;
        logic               v;
        logic               s;
        logic               e;
        logic signed [11:0] a;
        logic signed [11:0] b;
        logic signed [11:0] lv;
    } row_t;

    localparam int NROWS = 40;
    localparam row_t TBL [NROWS] = '{
        '{8'd8,  1'b1, 1'b0, 1'b1, 12'sd0,    12'sd0,    12'sd100},
        '{8'd1,  1'b1, 1'b0, 1'b1, 12'sd50,   12'sd0,    12'sd100},
        '{8'd1,  1'b1, 1'b0, 1'b1, 12'sd90,   12'sd0,    12'sd100},
        '{8'd1,  1'b1, 1'b0, 1'b1, 12'sd110,  12'sd0,    12'sd100},
        '{8'd1,  1'b1, 1'b0, 1'b1, 12'sd95,   12'sd0,    12'sd100},
        '{8'd1,  1'b1, 1'b0, 1'b1, 12'sd130,  12'sd0,    12'sd100},
        '{8'd1,  1'b1, 1'b0, 1'b1, 12'sd170,  12'sd0,    12'sd100},
        '{8'd1,  1'b1, 1'b0, 1'b1, 12'sd210,  12'sd0,    12'sd100},
        '{8'd2,  1'b0, 1'b0, 1'b1, 12'sd0,    12'sd0,    12'sd100},
        '{8'd1,  1'b1, 1'b0, 1'b1, 12'sd300,  12'sd0,    12'sd100},
        '{8'd1,  1'b1, 1'b0, 1'b1, 12'sd200,  12'sd0,    12'sd100},
        '{8'd1,  1'b1, 1'b0, 1'b1, 12'sd120,  12'sd0,    12'sd100},
        '{8'd1,  1'b1, 1'b0, 1'b1, 12'sd60,   12'sd0,    12'sd100},
        '{8'd1,  1'b1, 1'b0, 1'b1, -12'sd50,  12'sd0,    12'sd100},
        '{8'd1,  1'b1, 1'b0, 1'b1, 12'sd120,  12'sd0,    12'sd100},
        '{8'd12, 1'b0, 1'b0, 1'b1, 12'sd0,    12'sd0,    12'sd100},
        '{8'd1,  1'b1, 1'b0, 1'b1, -12'sd50,  12'sd0,    12'sd100},
        '{8'd1,  1'b1, 1'b0, 1'b1, -12'sd20,  12'sd0,    12'sd100},
        '{8'd1,  1'b1, 1'b0, 1'b1, 12'sd20,   12'sd0,    12'sd100},
        '{8'd1,  1'b1, 1'b0, 1'b1, 12'sd60,   12'sd0,    12'sd100},
        '{8'd1,  1'b1, 1'b0, 1'b1, 12'sd100,  12'sd0,    12'sd100},
        '{8'd1,  1'b1, 1'b0, 1'b1, 12'sd140,  12'sd0,    12'sd100},
        '{8'd4,  1'b1, 1'b0, 1'b1, -12'sd100, 12'sd0,    12'sd100},
        '{8'd1,  1'b1, 1'b0, 1'b0, -12'sd60,  12'sd0,    12'sd100},
        '{8'd1,  1'b1, 1'b0, 1'b0, 12'sd0,    12'sd0,    12'sd100},
        '{8'd1,  1'b1, 1'b0, 1'b0, 12'sd60,   12'sd0,    12'sd100},
        '{8'd1,  1'b1, 1'b0, 1'b0, 12'sd120,  12'sd0,    12'sd100},
        '{8'd1,  1'b1, 1'b0, 1'b0, 12'sd160,  12'sd0,    12'sd100},
        '{8'd4,  1'b1, 1'b1, 1'b1, 12'sd500,  -12'sd100, 12'sd0},
        '{8'd1,  1'b1, 1'b1, 1'b1, 12'sd500,  -12'sd50,  12'sd0},
        '{8'd1,  1'b1, 1'b1, 1'b1, -12'sd400, 12'sd0,    12'sd0},
        '{8'd1,  1'b1, 1'b1, 1'b1, -12'sd400, 12'sd50,   12'sd0},
        '{8'd1,  1'b1, 1'b1, 1'b1, -12'sd400, 12'sd100,  12'sd0},
        '{8'd6,  1'b1, 1'b0, 1'b1, -12'sd600, 12'sd0,    -12'sd200},
        '{8'd1,  1'b1, 1'b0, 1'b1, -12'sd500, 12'sd0,    -12'sd200},
        '{8'd1,  1'b1, 1'b0, 1'b1, -12'sd400, 12'sd0,    -12'sd200},
        '{8'd1,  1'b1, 1'b0, 1'b1, -12'sd300, 12'sd0,    -12'sd200},
        '{8'd1,  1'b1, 1'b0, 1'b1, -12'sd200, 12'sd0,    -12'sd200},
        '{8'd1,  1'b1, 1'b0, 1'b1, -12'sd100, 12'sd0,    -12'sd200},
        '{8'd1,  1'b1, 1'b0, 1'b1, 12'sd0,    12'sd0,    -12'sd200}
    };

    logic clk = 1'b0;
    logic rst;
    logic signed [11:0] smp_a, smp_b, trig_level;
    logic smp_vld, chan_sel, trig_en;
    logic trig_pulse, slope_rising;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    // reference state built from the requirements
    int  mh [4];
    int  mf [4];
    int  mseen;
    int  msince;
    bit  exp_slope;
    bit  exp_trig;
    int  pulses;

    always #(CLK_PERIOD/2) clk = ~clk;

    trig_slope_level #(.HOLDOFF(HOLD)) i_trig_slope_level (
        .clk          (clk),
        .rst          (rst),
        .smp_a        (smp_a),
        .smp_b        (smp_b),
        .smp_vld      (smp_vld),
        .chan_sel     (chan_sel),
        .trig_en      (trig_en),
        .trig_level   (trig_level),
        .trig_pulse   (trig_pulse),
        .slope_rising (slope_rising)
    );

    task automatic check(input bit got, input bit exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin mh[i] = 0; mf[i] = 0; end
        mseen = 0; msince = BIG; exp_slope = 0; exp_trig = 0;
    endtask

    // one clock: drive at the falling edge, predict, compare after the rising edge
    task automatic step(input bit v, input bit s, input bit e, input int a, input int b, input int lv);
        int x, f;
        bit sl;
        @(negedge clk);
        smp_vld = v; chan_sel = s; trig_en = e;
        smp_a = 12'(a); smp_b = 12'(b); trig_level = 12'(lv);
        x = s ? b : a;
        exp_trig = 1'b0;
        if (msince < BIG) msince++;
        if (v) begin
            f  = x + 2*mh[0] + 3*mh[1] + 2*mh[2] + mh[3];          // R1 kernel
            sl = (mseen >= 7) && (f - mf[3] > 0);                    // R2, R3
            if (e && mh[0] < lv && x >= lv && sl && msince > HOLD) begin // R4 R5 R6 R8
                exp_trig = 1'b1;
                msince = 0;
            end
            exp_slope = sl;
            for (int i = 3; i > 0; i--) begin mh[i] = mh[i-1]; mf[i] = mf[i-1]; end
            mh[0] = x; mf[0] = f;
            if (mseen < 8) mseen++;
        end
        @(posedge clk);
        #1;
        check(trig_pulse,   exp_trig,  "R4/R5/R6/R8/R9 trig_pulse");
        check(slope_rising, exp_slope, "R1/R2 slope_rising");
        if (trig_pulse) pulses++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; smp_vld = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        #1;
        check(trig_pulse,   1'b0, "R10 trig_pulse after reset");
        check(slope_rising, 1'b0, "R10 slope_rising after reset");
    endtask

    // crossing at pos 0, dip, second crossing `gap` cycles later
    task automatic holdoff_run(input int gap, input int exp_pulses);
        repeat (HOLD + 2) step(0, 0, 1, 0, 0, 100);
        repeat (5) step(1, 0, 1, 40, 0, 100);
        for (int k = 50; k < 100; k += 10) step(1, 0, 1, k, 0, 100);
        pulses = 0;
        step(1, 0, 1, 100, 0, 100);
        for (int k = 1; k <= gap - 2; k++) step(1, 0, 1, 100 + k, 0, 100);
        step(1, 0, 1, 98, 0, 100);
        step(1, 0, 1, 100 + gap + 2, 0, 100);
        n_checks++;
        if (pulses != exp_pulses) begin
            n_errors++;
            $display("FAIL R6: gap %0d gave %0d pulses, expected %0d", gap, pulses, exp_pulses);
        end
    endtask

    initial begin
        rst = 1'b1; smp_vld = 1'b0; chan_sel = 1'b0; trig_en = 1'b1;
        smp_a = '0; smp_b = '0; trig_level = '0;
        model_reset();
        do_reset();

        // R3: rising ramp, flag held low through the seventh sample
        for (int k = 1; k <= 7; k++) step(1, 0, 1, 10*k, 0, 2000);
        check(slope_rising, 1'b0, "R3 low after seven samples");
        step(1, 0, 1, 80, 0, 2000);
        check(slope_rising, 1'b1, "R3 high at eighth sample");

        // table walk
        pulses = 0;
        for (int r = 0; r < NROWS; r++) begin
            for (int k = 0; k < int'(TBL[r].rep); k++) begin
                step(TBL[r].v, TBL[r].s, TBL[r].e,
                     int'(TBL[r].a), int'(TBL[r].b), int'(TBL[r].lv));
            end
        end

        // R6: crossing at exactly HOLD cycles blocked, HOLD+1 allowed
        holdoff_run(HOLD, 1);
        holdoff_run(HOLD + 1, 2);

        // R7: pulse never two cycles wide (one idle step after a pulse)
        step(0, 0, 1, 0, 0, 100);
        check(trig_pulse, 1'b0, "R7 no second pulse cycle");

        // mid-run reset
        do_reset();

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule